// File: doc/BRIEF.md
# PCI Window Control Register File

This block is the register bank that sits in front of a PCI host bridge's system-to-PCI memory windows. Software writes eight 32-bit registers through a simple word-wide request port: three inbound map registers that place the three memory windows in PCI memory space, three outbound map registers, an identity register and a flags register. Only the inbound map registers steer address translation. The others are storage that software reads back.

From the inbound map registers the block continuously produces the PCI base address of each memory window. It also translates a window-relative offset into a full 32-bit PCI address for the bridge datapath, and flags offsets that fall outside the selected window. A fourth selector value picks the fixed I/O window, which always starts at PCI I/O address zero. A build-time variant picks one of two base-derivation rules and one of two sets of window sizes.

Top module: `pciw_ctrl_regs`

## Requirements
- R1: After synchronous reset, all eight registers read zero, every window base is zero, and `bus_ack` and `xl_ack` are low.
- R2: The register offsets are: 0x00/0x04/0x08 inbound map 0/1/2, 0x0C identity, 0x10 flags, 0x14/0x18/0x1C outbound map 0/1/2. A word write stores the full 32-bit value and a later read returns it.
- R3: `bus_size` 2'b10 is the only valid size (32-bit). With any other code a write changes nothing, and a read returns zero. Both set `bus_err`.
- R4: An access to any offset not listed in R2 raises `bus_err`. This includes non-word-aligned offsets and offsets at or above 0x20. A read returns zero and a write changes no register.
- R5: `bus_ack` is high for exactly the cycle after each accepted request, for reads and writes alike. `bus_err` is low on valid accesses.
- R6: With `ALT_MAP`=0, window i's base is bits [3:0] of inbound map i placed in address bits [31:28], with all lower bits zero.
- R7: With `ALT_MAP`=1, window i's base is inbound map i with the bits below the window size cleared.
- R8: Window sizes are 0x0C000000/0x10000000/0x10000000 with `ALT_MAP`=0 and 0x01000000/0x04000000/0x08000000 with `ALT_MAP`=1. `xl_oor` is set exactly when the offset is greater than or equal to the selected size.
- R9: A translation request on `xl_sel` 0..2 returns, one cycle later with `xl_ack`, the base OR (offset AND span mask). The span mask is the smallest all-ones value covering size-1: 0x0FFFFFFF for all windows when `ALT_MAP`=0, and size-1 when `ALT_MAP`=1.
- R10: `xl_sel`=3 selects the I/O window. The result is offset AND 0xFFFFF, with `xl_oor` set for offsets at or above 0x100000, regardless of any register.
- R11: Writes to the identity, flags and outbound map registers leave every window base and translation result unchanged.
- R12: A translation requested in the cycle right after an inbound map write uses the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | REG_AW | Byte offset into the register bank |
| bus_size | input | 2 | Access size code; 2'b10 = 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response valid, one cycle after request |
| bus_rdata | output | 32 | Read data (zero on error or write) |
| bus_err | output | 1 | Bad offset or bad size |
| xl_req | input | 1 | Translation request |
| xl_sel | input | 2 | Window select: 0..2 memory, 3 I/O |
| xl_offset | input | 32 | Offset within the window |
| xl_ack | output | 1 | Translation result valid |
| xl_addr | output | 32 | Translated PCI address |
| xl_oor | output | 1 | Offset outside the window |
| win_base | output | 96 | Window bases, window i at bits [32i+31:32i] |

## Verification
Both variants are instantiated side by side on one stimulus stream, so a design that mixes up the nibble-shift rule with the size-mask rule gives the wrong base in one of the two. Offsets exactly at size-1 and at size are tried in every window, which catches an off-by-one in the range compare. Window 0 of the nibble variant has a size that is not a power of two, and an offset with bit 26 set catches a span mask taken as size-1. Bad sizes, unaligned offsets and offsets beyond 0x1C are each followed by a readback of the targeted register, which exposes a decode that ignores high or low address bits. A translation placed in the cycle right after an inbound map write exposes a base pipelined one stage too late.

// File: rtl/pciw_pkg.sv
package pciw_pkg;
  localparam int DW   = 32;
  localparam int NWIN = 3;
  localparam int NREG = 8;

  typedef enum logic [2:0] {
    RI_IN0, RI_IN1, RI_IN2, RI_IDENT, RI_FLAGS, RI_OUT0, RI_OUT1, RI_OUT2
  } reg_idx_e;

  typedef logic [NWIN-1:0][DW-1:0] win_vec_t;

  localparam logic [1:0]    SZ_WORD = 2'b10;
  localparam logic [1:0]    SEL_IO  = 2'd3;
  localparam logic [DW-1:0] IO_SIZE = 32'h0010_0000;

  function automatic win_vec_t size_table(input bit alt);
    win_vec_t t;
    if (alt) begin
      t[0] = 32'h0100_0000;
      t[1] = 32'h0400_0000;
      t[2] = 32'h0800_0000;
    end else begin
      t[0] = 32'h0C00_0000;
      t[1] = 32'h1000_0000;
      t[2] = 32'h1000_0000;
    end
    return t;
  endfunction

  // Smallest 2^k-1 that covers every in-range offset.
  function automatic logic [DW-1:0] span_of(input logic [DW-1:0] sz);
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < DW; k++) begin
      if (m < sz - 1) m = {m[DW-2:0], 1'b1};
    end
    return m;
  endfunction
endpackage

// File: rtl/pciw_reg_bank.sv
module pciw_reg_bank
  import pciw_pkg::*;
#(
  parameter int REG_AW = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic [REG_AW-1:0]        bus_addr,
  input  logic [1:0]               bus_size,
  input  logic [DW-1:0]            bus_wdata,
  output logic                     bus_ack,
  output logic [DW-1:0]            bus_rdata,
  output logic                     bus_err,
  output logic [NREG-1:0][DW-1:0]  regs_q
);
  localparam int IDX_W   = $clog2(NREG);
  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0] idx;
  logic             hit;

  assign idx = bus_addr[IDX_MSB:IDX_LSB];
  assign hit = (bus_addr[IDX_LSB-1:0] == '0) &&
               (bus_addr[REG_AW-1:IDX_MSB+1] == '0) &&
               (bus_size == SZ_WORD);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (bus_req && bus_we && hit && (idx == IDX_W'(g))) begin
        regs_q[g] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_err   <= bus_req && !hit;
      bus_rdata <= (bus_req && !bus_we && hit) ? regs_q[idx] : '0;
    end
  end
endmodule

// File: rtl/pciw_win_xlate.sv
module pciw_win_xlate
  import pciw_pkg::*;
#(
  parameter bit ALT_MAP = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  win_vec_t        inmap,
  input  logic            xl_req,
  input  logic [1:0]      xl_sel,
  input  logic [DW-1:0]   xl_offset,
  output win_vec_t        win_base,
  output logic            xl_ack,
  output logic [DW-1:0]   xl_addr,
  output logic            xl_oor
);
  localparam win_vec_t SIZES = size_table(ALT_MAP);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    if (ALT_MAP) begin : g_mask
      assign win_base[w] = inmap[w] & ~(SIZES[w] - 1);
    end else begin : g_nib
      assign win_base[w] = {inmap[w][3:0], {(DW-4){1'b0}}};
    end
  end

  logic [DW-1:0] sel_base, sel_size, sel_span;

  always_comb begin
    sel_base = '0;
    sel_size = IO_SIZE;
    sel_span = IO_SIZE - 1;
    for (int w = 0; w < NWIN; w++) begin
      if (xl_sel == 2'(w)) begin
        sel_base = win_base[w];
        sel_size = SIZES[w];
        sel_span = span_of(SIZES[w]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_ack  <= 1'b0;
      xl_addr <= '0;
      xl_oor  <= 1'b0;
    end else begin
      xl_ack <= xl_req;
      if (xl_req) begin
        xl_addr <= sel_base | (xl_offset & sel_span);
        xl_oor  <= (xl_offset >= sel_size);
      end
    end
  end
endmodule

// File: rtl/pciw_ctrl_regs.sv
module pciw_ctrl_regs
  import pciw_pkg::*;
#(
  parameter int REG_AW  = 12,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_ack,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  input  logic                 xl_req,
  input  logic [1:0]           xl_sel,
  input  logic [31:0]          xl_offset,
  output logic                 xl_ack,
  output logic [31:0]          xl_addr,
  output logic                 xl_oor,
  output logic [3*32-1:0]      win_base
);
  logic [NREG-1:0][DW-1:0] regs_q;
  win_vec_t                inmap;
  win_vec_t                bases;

  pciw_reg_bank #(.REG_AW(REG_AW)) u_bank (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .regs_q(regs_q)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_in
    assign inmap[w] = regs_q[int'(RI_IN0) + w];
  end

  pciw_win_xlate #(.ALT_MAP(ALT_MAP)) u_xlate (
    .clk(clk), .rst(rst), .inmap(inmap),
    .xl_req(xl_req), .xl_sel(xl_sel), .xl_offset(xl_offset),
    .win_base(bases), .xl_ack(xl_ack), .xl_addr(xl_addr), .xl_oor(xl_oor)
  );

  assign win_base = bases;
endmodule

// File: rtl/pciw_ctrl_regs_chk.sv
module pciw_ctrl_regs_chk #(
  parameter int REG_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_ack,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              xl_req,
  input logic [1:0]        xl_sel,
  input logic [31:0]       xl_offset,
  input logic              xl_ack,
  input logic [31:0]       xl_addr,
  input logic              xl_oor,
  input logic [95:0]       win_base
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (win_base == '0) && !bus_ack && !xl_ack);

  p_bad_size_err_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_size != 2'b10) |=> bus_err);

  p_err_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && bus_err) |-> (bus_rdata == '0));

  p_ack_follows_req_r5: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack);

  p_no_spurious_ack_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ack);

  p_io_oor_r10: assert property (@(posedge clk) disable iff (rst)
    (xl_req && xl_sel == 2'd3 && xl_offset >= 32'h0010_0000) |=> (xl_oor && xl_ack));

  p_io_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (xl_req && xl_sel == 2'd3) |=> (xl_addr[31:20] == '0));

  p_base_only_on_write_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_req && bus_we)) |-> $stable(win_base));
endmodule

bind pciw_ctrl_regs pciw_ctrl_regs_chk #(.REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_ack(bus_ack),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .xl_req(xl_req),
  .xl_sel(xl_sel), .xl_offset(xl_offset), .xl_ack(xl_ack),
  .xl_addr(xl_addr), .xl_oor(xl_oor), .win_base(win_base)
);

// File: tb/pciw_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module pciw_ctrl_regs_tb_top;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0] bus_size = 2'b10;
  logic [31:0] bus_wdata = '0;
  logic xl_req = 1'b0;
  logic [1:0] xl_sel = '0;
  logic [31:0] xl_offset = '0;

  logic ack0, ack1, err0, err1, xa0, xa1, oor0, oor1;
  logic [31:0] rd0, rd1, xad0, xad1;
  logic [95:0] wb0, wb1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pciw_ctrl_regs #(.REG_AW(AW), .ALT_MAP(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ack(ack0), .bus_rdata(rd0),
    .bus_err(err0), .xl_req(xl_req), .xl_sel(xl_sel), .xl_offset(xl_offset),
    .xl_ack(xa0), .xl_addr(xad0), .xl_oor(oor0), .win_base(wb0));

  pciw_ctrl_regs #(.REG_AW(AW), .ALT_MAP(1'b1)) dut_alt_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ack(ack1), .bus_rdata(rd1),
    .bus_err(err1), .xl_req(xl_req), .xl_sel(xl_sel), .xl_offset(xl_offset),
    .xl_ack(xa1), .xl_addr(xad1), .xl_oor(oor1), .win_base(wb1));

  // Model state
  logic [31:0] mreg [8];

  function automatic logic [31:0] wsize(bit alt, int i);
    if (alt) return (i == 0) ? 32'h0100_0000 : (i == 1) ? 32'h0400_0000 : 32'h0800_0000;
    return (i == 0) ? 32'h0C00_0000 : 32'h1000_0000;
  endfunction
  function automatic logic [31:0] wspan(bit alt, int i);
    if (alt) return wsize(1'b1, i) - 1;
    return 32'h0FFF_FFFF;
  endfunction
  function automatic logic [31:0] ebase(bit alt, int i);
    if (alt) return mreg[i] & ~(wsize(1'b1, i) - 1);
    return {mreg[i][3:0], 28'h0};
  endfunction

  task automatic chk(string req, string what, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus(bit we, logic [AW-1:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'b10;
  endtask

  task automatic xl(logic [1:0] s, logic [31:0] off);
    @(negedge clk);
    xl_req = 1'b1; xl_sel = s; xl_offset = off;
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  task automatic wr_ok(int r, logic [31:0] d);
    bus(1'b1, AW'(r * 4), 2'b10, d);
    mreg[r] = d;
    chk("R5", "write ack", {ack0, ack1, err0, err1}, 4'b1100);
  endtask

  task automatic rd_expect(string req, int r, logic [31:0] e);
    bus(1'b0, AW'(r * 4), 2'b10, '0);
    chk(req, $sformatf("read reg %0d", r), {rd0, rd1}, {e, e});
    chk("R5", "read ack/err", {ack0, ack1, err0, err1}, 4'b1100);
  endtask

  task automatic xl_expect(string req, logic [1:0] s, logic [31:0] off);
    logic [31:0] e0, e1;
    bit o0, o1;
    xl(s, off);
    if (s == 2'd3) begin
      e0 = off & 32'h000F_FFFF; e1 = e0;
      o0 = off >= 32'h0010_0000; o1 = o0;
    end else begin
      e0 = ebase(1'b0, s) | (off & wspan(1'b0, s));
      e1 = ebase(1'b1, s) | (off & wspan(1'b1, s));
      o0 = off >= wsize(1'b0, s);
      o1 = off >= wsize(1'b1, s);
    end
    chk(req, $sformatf("xlate sel%0d off %0h", s, off),
        {xa0, xa1, o0 ^ oor0, o1 ^ oor1, xad0, xad1}, {1'b1, 1'b1, 2'b00, e0, e1});
  endtask

  task automatic chk_bases(string req);
    chk(req, "bases nibble", wb0, {ebase(1'b0, 2), ebase(1'b0, 1), ebase(1'b0, 0)});
    chk(req, "bases masked", wb1, {ebase(1'b1, 2), ebase(1'b1, 1), ebase(1'b1, 0)});
  endtask

  // R1
  task automatic t_reset();
    for (int r = 0; r < 8; r++) mreg[r] = '0;
    chk("R1", "acks after reset", {ack0, ack1, xa0, xa1}, 4'b0);
    chk("R1", "bases after reset", {wb0, wb1}, '0);
    for (int r = 0; r < 8; r++) rd_expect("R1", r, 32'h0);
  endtask

  // R2 R6 R7
  task automatic t_readback();
    logic [31:0] v [8] = '{32'hA5C3_7F19, 32'h1234_5678, 32'hFEDC_BA9E,
                            32'h0BAD_F00D, 32'h8000_0001, 32'h1111_2222,
                            32'h3333_4444, 32'hCAFE_0007};
    for (int r = 0; r < 8; r++) wr_ok(r, v[r]);
    for (int r = 0; r < 8; r++) rd_expect("R2", r, v[r]);
    chk_bases("R6 R7");
    @(negedge clk);
    chk("R5", "ack drops", {ack0, ack1}, 2'b00);
  endtask

  // R3
  task automatic t_bad_size();
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      bus(1'b1, AW'(12), 2'(s), 32'hDEAD_BEEF);
      chk("R3", "bad size write err", {ack0, ack1, err0, err1}, 4'b1111);
      bus(1'b0, AW'(12), 2'(s), '0);
      chk("R3", "bad size read zero", {err0, err1, rd0, rd1}, {2'b11, 64'h0});
    end
    rd_expect("R3", 3, mreg[3]);
  endtask

  // R4
  task automatic t_bad_offset();
    logic [AW-1:0] offs [4] = '{12'h020, 12'h006, 12'h101, 12'h81C};
    for (int k = 0; k < 4; k++) begin
      bus(1'b1, offs[k], 2'b10, 32'h5555_AAAA);
      chk("R4", "bad offset write err", {err0, err1}, 2'b11);
      bus(1'b0, offs[k], 2'b10, '0);
      chk("R4", "bad offset read", {err0, err1, rd0, rd1}, {2'b11, 64'h0});
    end
    for (int r = 0; r < 8; r++) rd_expect("R4", r, mreg[r]);
    chk_bases("R4");
  endtask

  // R8 R9
  task automatic t_windows();
    wr_ok(0, 32'h0000_0003);
    wr_ok(1, 32'h1F3A_0006);
    wr_ok(2, 32'hF7C0_0009);
    chk_bases("R6 R7");
    for (int w = 0; w < 3; w++) begin
      xl_expect("R9", 2'(w), 32'h0000_1234);
      xl_expect("R9", 2'(w), 32'h0456_789C);
      xl_expect("R8", 2'(w), wsize(1'b1, w) - 1);
      xl_expect("R8", 2'(w), wsize(1'b1, w));
      xl_expect("R8", 2'(w), wsize(1'b0, w) - 1);
      xl_expect("R8", 2'(w), wsize(1'b0, w));
      xl_expect("R8", 2'(w), 32'hFFFF_FFFF);
    end
  endtask

  // R10
  task automatic t_io();
    xl_expect("R10", 2'd3, 32'h0000_0000);
    xl_expect("R10", 2'd3, 32'h000F_FFFF);
    xl_expect("R10", 2'd3, 32'h0010_0000);
    xl_expect("R10", 2'd3, 32'h8012_3456);
  endtask

  // R11
  task automatic t_inert();
    logic [95:0] b0, b1;
    b0 = wb0; b1 = wb1;
    wr_ok(3, 32'hFFFF_FFFF);
    wr_ok(4, 32'h0F0F_0F0F);
    wr_ok(5, 32'h7777_7777);
    wr_ok(6, 32'h0000_0001);
    wr_ok(7, 32'h8888_8888);
    chk("R11", "bases unchanged", {wb0, wb1}, {b0, b1});
    xl_expect("R11", 2'd1, 32'h0000_0ABC);
    xl_expect("R11", 2'd2, 32'h0123_4567);
  endtask

  // R12
  task automatic t_back_to_back();
    logic [31:0] off;
    off = 32'h0000_0100;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(4); bus_size = 2'b10;
    bus_wdata = 32'h2A00_000B;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    mreg[1] = 32'h2A00_000B;
    xl_req = 1'b1; xl_sel = 2'd1; xl_offset = off;
    @(negedge clk);
    xl_req = 1'b0;
    chk("R12", "new map used at once", {xad0, xad1},
        {ebase(1'b0, 1) | off, ebase(1'b1, 1) | off});
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_bad_size();
    t_bad_offset();
    t_windows();
    t_io();
    t_inert();
    t_back_to_back();
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule